// File: doc/BRIEF.md
# Per-Core Ordered Store Queue with Load Forwarding

This block sits between one core and a single memory request port and gives total-store-order behaviour. Stores from the core go into a circular queue and are written to memory one at a time, oldest first. Loads never enter the queue. A load whose address matches a queued store is answered from the youngest such entry. Any other load is sent to memory, ahead of the queued stores, so a load may complete while older stores to other addresses are still waiting.

A fence input stops new core traffic until the queue is empty. While a fence waits, the memory port is used only for draining. The memory port is a valid/ready request channel with a separate read-response strobe, and it handles requests in the order it accepts them. At most one memory load is outstanding at a time. The number of queued stores is always visible on an occupancy output.

Top module: `tso_store_queue`

## Requirements
- R1: Queued stores are written to memory (mem_req_we=1) exactly once each, in the order the core issued them.
- R2: A load whose address matches no queued entry is issued to memory (mem_req_we=0) while older stores to other addresses stay queued, and returns the memory value.
- R3: A load whose address matches a queued entry returns that entry's data with ld_rsp_valid one cycle after acceptance and makes no memory read.
- R4: When several queued entries match a load address, the data of the most recently issued one is returned.
- R5: A store and a load accepted in the same cycle are ordered load first: the load does not see that store's data.
- R6: With DEPTH entries occupied, st_ready is 0 until an entry drains; loads that hit a queued entry are still accepted.
- R7: `occupancy` equals the number of queued stores at all times.
- R8: When a load miss and a pending drain compete in one cycle with no fence waiting, the port carries the load (mem_req_we=0).
- R9: While fence_valid is 1 and the queue is not empty, fence_ready, st_ready and ld_ready are 0 and the port carries only drains. fence_ready rises after one cycle per queued store when memory is always ready.
- R10: A fence raised with an empty queue sees fence_ready=1 in the same cycle.
- R11: Reset empties the queue: occupancy is 0, st_ready is 1, no memory request is made, and earlier stores are not forwarded.
- R12: While a memory load is outstanding, ld_ready is 0. The read data appears on ld_rsp_data, with ld_rsp_valid, one cycle after mem_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Core load request |
| ld_ready | output | 1 | Load accepted this cycle when high with ld_valid |
| ld_addr | input | ADDR_W | Load address |
| ld_rsp_valid | output | 1 | Load result strobe |
| ld_rsp_data | output | DATA_W | Load result |
| fence_valid | input | 1 | Fence request, held until fence_ready |
| fence_ready | output | 1 | Fence complete (queue empty) |
| occupancy | output | $clog2(DEPTH+1) | Number of queued stores |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write (drain), 0 = read (load) |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Write data for drains |
| mem_rsp_valid | input | 1 | Read data strobe from memory |
| mem_rsp_rdata | input | DATA_W | Read data from memory |

## Verification
Two functions can land in the same cycle: a load that misses the queue and the drain of the oldest store. Both want the single memory port. The bench fills the queue with memory stalled, then in one cycle opens the port and presents a missing load. It checks that the first accepted request is a read, that the occupancy still shows every store at that moment, and that the stores then leave in issue order. A second case pairs a same-cycle store and load to one address, and the bench judges the pair by the value the load returns.

// File: rtl/tso_sq_pkg.sv
package tso_sq_pkg;

  // which requester owns the memory port in a given cycle
  typedef enum logic {
    PORT_LOAD  = 1'b0,
    PORT_DRAIN = 1'b1
  } port_sel_e;

endpackage

// File: rtl/sq_entry_store.sv
module sq_entry_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DEPTH-1:0][AW-1:0]   ent_addr,
  output logic [DEPTH-1:0][DW-1:0]   ent_data,
  output logic [PW-1:0]              head_ptr,
  output logic [CW-1:0]              count,
  output logic                       full,
  output logic                       empty
);

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + PW'(1);
    if (pop)  rd_d = rd_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // payload storage carries no reset; occupancy decides validity
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= push_addr;
      data_q[wr_q] <= push_data;
    end
  end

  assign ent_addr = addr_q;
  assign ent_data = data_q;
  assign head_ptr = rd_q;
  assign count    = cnt_q;
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  a_r1_pop_from_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [PW-1:0]            head_ptr,
  input  logic [CW-1:0]            count,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);

  logic [PW-1:0] idx;
  logic [PW-1:0] sel;

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit = 1'b0;
    sel = head_ptr;
    idx = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PW'(k);
      if ((CW'(k) < count) && (ent_addr[idx] == look_addr)) begin
        hit = 1'b1;
        sel = idx;
      end
    end
    hit_data = ent_data[sel];
  end

endmodule

// File: rtl/sq_port_arb.sv
module sq_port_arb
  import tso_sq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_hit,
  input  logic [DW-1:0] ld_hit_data,
  input  logic          fence_valid,
  input  logic          q_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          ld_ready,
  output logic          ld_rsp_valid,
  output logic [DW-1:0] ld_rsp_data,
  output logic          drain,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);

  port_sel_e     sel;
  logic          ld_open;
  logic          ld_miss_req;
  logic          ld_take;
  logic          fwd_take;
  logic          miss_take;
  logic          busy_q, busy_d;
  logic          rsp_v_q, rsp_v_d;
  logic [DW-1:0] rsp_d_q, rsp_d_d;
  logic          rsp_en;

  // a waiting fence shuts the load path, which leaves the port to drains
  assign ld_open     = !fence_valid && !busy_q;
  assign ld_miss_req = ld_valid && ld_open && !ld_hit;
  assign ld_ready    = ld_open && (ld_hit || mem_req_ready);
  assign ld_take     = ld_valid && ld_ready;
  assign fwd_take    = ld_take && ld_hit;
  assign miss_take   = ld_take && !ld_hit;

  always_comb begin
    sel           = ld_miss_req ? PORT_LOAD : PORT_DRAIN;
    mem_req_valid = ld_miss_req || !q_empty;
    mem_req_we    = (sel == PORT_DRAIN);
    mem_req_addr  = (sel == PORT_LOAD) ? ld_addr : head_addr;
    mem_req_wdata = head_data;
    drain         = (sel == PORT_DRAIN) && !q_empty && mem_req_ready;
  end

  always_comb begin
    busy_d = busy_q;
    if (miss_take)          busy_d = 1'b1;
    else if (mem_rsp_valid) busy_d = 1'b0;
    rsp_v_d = fwd_take || (busy_q && mem_rsp_valid);
    rsp_en  = rsp_v_d;
    rsp_d_d = fwd_take ? ld_hit_data : mem_rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) rsp_d_q <= rsp_d_d;
  end

  assign ld_rsp_valid = rsp_v_q;
  assign ld_rsp_data  = rsp_d_q;

  a_r3_fwd_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ld_hit) |-> !(mem_req_valid && !mem_req_we && mem_req_ready));

  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mem_rsp_valid) |=> ld_rsp_valid);

  a_r12_blocked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_valid && ld_ready && !ld_hit) |-> !ld_ready);

endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       st_valid,
  output logic                       st_ready,
  input  logic [ADDR_W-1:0]          st_addr,
  input  logic [DATA_W-1:0]          st_data,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic [ADDR_W-1:0]          ld_addr,
  output logic                       ld_rsp_valid,
  output logic [DATA_W-1:0]          ld_rsp_data,
  input  logic                       fence_valid,
  output logic                       fence_ready,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_we,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [DATA_W-1:0]          mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [DATA_W-1:0]          mem_rsp_rdata
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [PTR_W-1:0]             head_ptr;
  logic [CNT_W-1:0]             count;
  logic                         q_full;
  logic                         q_empty;
  logic                         push;
  logic                         drain;
  logic                         fwd_hit;
  logic [DATA_W-1:0]            fwd_data;

  assign st_ready    = !q_full && !fence_valid;
  assign push        = st_valid && st_ready;
  assign fence_ready = q_empty;
  assign occupancy   = count;

  sq_entry_store #(
    .DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .PW(PTR_W), .CW(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (drain),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .full      (q_full),
    .empty     (q_empty)
  );

  sq_fwd_search #(
    .DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .PW(PTR_W), .CW(CNT_W)
  ) u_search (
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .look_addr (ld_addr),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  sq_port_arb #(
    .AW(ADDR_W), .DW(DATA_W)
  ) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_valid      (ld_valid),
    .ld_addr       (ld_addr),
    .ld_hit        (fwd_hit),
    .ld_hit_data   (fwd_data),
    .fence_valid   (fence_valid),
    .q_empty       (q_empty),
    .head_addr     (ent_addr[head_ptr]),
    .head_data     (ent_data[head_ptr]),
    .ld_ready      (ld_ready),
    .ld_rsp_valid  (ld_rsp_valid),
    .ld_rsp_data   (ld_rsp_data),
    .drain         (drain),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  a_r9_fence_blocks_core: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !fence_ready) |-> (!st_ready && !ld_ready));

  a_r9_fence_only_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && mem_req_valid) |-> mem_req_we);

  a_r6_full_stalls_store: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> !st_ready);

  a_r1_write_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (occupancy != '0));

endmodule

// File: tb/tso_store_queue_bench.sv
`timescale 1ns/1ps
module tso_store_queue_bench;

  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int CW    = $clog2(DEPTH+1);

  logic          clk;
  logic          rst_n;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          ld_valid, ld_ready;
  logic [AW-1:0] ld_addr;
  logic          ld_rsp_valid;
  logic [DW-1:0] ld_rsp_data;
  logic          fence_valid, fence_ready;
  logic [CW-1:0] occupancy;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  int checks;
  int failures;
  bit done;

  tso_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_tso_store_queue (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .fence_valid(fence_valid), .fence_ready(fence_ready), .occupancy(occupancy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model: in-order, two-cycle read latency, logs every write
  logic [DW-1:0] mem_arr [0:255];
  logic [AW-1:0] wlog_addr [0:255];
  logic [DW-1:0] wlog_data [0:255];
  int            wr_n;
  int            rd_n;
  int            rd_cnt;
  logic [DW-1:0] rd_buf;

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'hC0DE_0000 + i;
    wr_n = 0; rd_n = 0; rd_cnt = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rd_cnt == 1) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= rd_buf;
      rd_cnt <= 0;
    end else if (rd_cnt > 1) begin
      rd_cnt <= rd_cnt - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem_arr[mem_req_addr[7:0]] <= mem_req_wdata;
        wlog_addr[wr_n[7:0]] <= mem_req_addr;
        wlog_data[wr_n[7:0]] <= mem_req_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_buf <= mem_arr[mem_req_addr[7:0]];
        rd_cnt <= 2;
        rd_n   <= rd_n + 1;
      end
    end
  end

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_store(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_load(string req, logic [AW-1:0] a, logic [DW-1:0] exp, bit want_fwd);
    int rd0;
    int lat;
    rd0 = rd_n;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a;
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ld_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ld_rsp_valid && lat < 20);
    check_eq(req, "load data", ld_rsp_data, exp);
    if (want_fwd) begin
      check_eq(req, "forward latency", lat, 1);
      check_eq(req, "no memory read on hit", rd_n, rd0);
    end
  endtask

  task automatic drain_all();
    @(negedge clk);
    mem_req_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (occupancy == 0) break;
      @(negedge clk);
    end
    check_eq("R7", "queue empty after drain", occupancy, 0);
  endtask

  task automatic t_reset_state();
    check_eq("R11", "occupancy after reset", occupancy, 0);
    check_eq("R11", "st_ready after reset", st_ready, 1);
    check_eq("R11", "no request after reset", mem_req_valid, 0);
    check_eq("R10", "fence_ready when empty", fence_ready, 1);
  endtask

  task automatic t_store_order();
    int base;
    base = wr_n;
    @(negedge clk); mem_req_ready = 1'b0;
    for (int i = 0; i < 4; i++) put_store(AW'(16'h0100 + 3 - i), 32'hA000_0000 + i);
    @(negedge clk);
    check_eq("R7", "occupancy with four queued", occupancy, 4);
    drain_all();
    check_eq("R1", "write count", wr_n - base, 4);
    for (int i = 0; i < 4; i++) begin
      check_eq("R1", "write order addr", wlog_addr[base + i], 16'h0100 + 3 - i);
      check_eq("R1", "write order data", wlog_data[base + i], 32'hA000_0000 + i);
    end
  endtask

  task automatic t_load_bypass();
    int w0;
    @(negedge clk); mem_req_ready = 1'b0;
    put_store(16'h0010, 32'h1111_0010);
    put_store(16'h0011, 32'h1111_0011);
    @(negedge clk);
    mem_req_ready = 1'b1; ld_valid = 1'b1; ld_addr = 16'h0040;
    #1;
    w0 = wr_n;
    check_eq("R8", "load owns port", {mem_req_valid, mem_req_we}, 2'b10);
    check_eq("R8", "load accepted", ld_ready, 1);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    check_eq("R2", "stores still queued at load issue", occupancy, 2);
    check_eq("R2", "no write before load", wr_n, w0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ld_rsp_valid) break;
    end
    check_eq("R2", "miss returns memory value", ld_rsp_data, 32'hC0DE_0040);
    drain_all();
    check_eq("R1", "bypassed stores in order", wlog_addr[w0], 16'h0010);
  endtask

  task automatic t_forward();
    @(negedge clk); mem_req_ready = 1'b0;
    put_store(16'h0020, 32'hAAAA_0020);
    do_load("R3", 16'h0020, 32'hAAAA_0020, 1'b1);
    put_store(16'h0030, 32'h0000_0001);
    put_store(16'h0031, 32'h0000_0002);
    put_store(16'h0030, 32'h0000_0003);
    do_load("R4", 16'h0030, 32'h0000_0003, 1'b1);
    drain_all();
  endtask

  task automatic t_same_cycle();
    @(negedge clk); mem_req_ready = 1'b0;
    put_store(16'h0050, 32'h0000_0005);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0050; st_data = 32'h0000_0006;
    ld_valid = 1'b1; ld_addr = 16'h0050;
    #1;
    check_eq("R5", "both accepted", {st_ready, ld_ready}, 2'b11);
    @(posedge clk); #1;
    st_valid = 1'b0; ld_valid = 1'b0;
    @(negedge clk);
    check_eq("R5", "load sees older value", {ld_rsp_valid, ld_rsp_data}, {1'b1, 32'h0000_0005});
    do_load("R5", 16'h0050, 32'h0000_0006, 1'b1);
    drain_all();
  endtask

  task automatic t_full();
    int base;
    base = wr_n;
    @(negedge clk); mem_req_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) put_store(AW'(16'h0060 + i), 32'h0600 + i);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0070; st_data = 32'hDEAD;
    #1;
    check_eq("R6", "occupancy full", occupancy, DEPTH);
    check_eq("R6", "st_ready low when full", st_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    check_eq("R6", "still stalled", st_ready, 0);
    st_valid = 1'b0;
    do_load("R6", 16'h0063, 32'h0000_0603, 1'b1);
    drain_all();
    for (int i = 0; i < DEPTH; i++)
      check_eq("R1", "full drain order", wlog_addr[base + i], 16'h0060 + i);
  endtask

  task automatic t_fence();
    int stall;
    @(negedge clk); mem_req_ready = 1'b0;
    put_store(16'h0080, 32'h8);
    put_store(16'h0081, 32'h9);
    put_store(16'h0082, 32'hA);
    @(negedge clk);
    fence_valid = 1'b1; st_valid = 1'b1; st_addr = 16'h0090; st_data = 32'h1;
    ld_valid = 1'b1; ld_addr = 16'h0091;
    #1;
    check_eq("R9", "fence waits", fence_ready, 0);
    check_eq("R9", "core stalled", {st_ready, ld_ready}, 2'b00);
    check_eq("R9", "drain owns port", {mem_req_valid, mem_req_we}, 2'b11);
    st_valid = 1'b0; ld_valid = 1'b0;
    mem_req_ready = 1'b1;
    stall = 0;
    while (!fence_ready && stall < 50) begin @(negedge clk); #1; stall++; end
    check_eq("R9", "stall cycles equal queued stores", stall, 3);
    fence_valid = 1'b0;
    @(negedge clk);
    fence_valid = 1'b1;
    #1;
    check_eq("R10", "empty fence completes at once", fence_ready, 1);
    fence_valid = 1'b0;
  endtask

  task automatic t_one_outstanding();
    @(negedge clk); mem_req_ready = 1'b1;
    ld_valid = 1'b1; ld_addr = 16'h0042;
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ld_addr = 16'h0043;
    @(negedge clk); #1;
    check_eq("R12", "ld_ready low while read outstanding", ld_ready, 0);
    @(negedge clk); #1;
    check_eq("R12", "ld_ready still low", ld_ready, 0);
    ld_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (ld_rsp_valid) break;
      @(negedge clk);
    end
    check_eq("R12", "read data returned", {ld_rsp_valid, ld_rsp_data}, {1'b1, 32'hC0DE_0042});
  endtask

  task automatic t_reset_mid();
    @(negedge clk); mem_req_ready = 1'b0;
    put_store(16'h00A0, 32'hBAD0_00A0);
    put_store(16'h00A1, 32'hBAD0_00A1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R11", "reset empties queue", occupancy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_eq("R11", "no request after mid reset", mem_req_valid, 0);
    mem_req_ready = 1'b1;
    do_load("R11", 16'h00A0, 32'hC0DE_00A0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    st_valid = 1'b0; st_addr = '0; st_data = '0;
    ld_valid = 1'b0; ld_addr = '0;
    fence_valid = 1'b0; mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_state();
    t_store_order();
    t_load_bypass();
    t_forward();
    t_same_cycle();
    t_full();
    t_fence();
    t_one_outstanding();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule